// File: doc/BRIEF.md
# Paged Edge-Interrupt Parallel I/O Controller

This block provides 48 general-purpose lines, grouped as six byte-wide ports, behind a simple byte-wide register bus with a 16-byte address window. Each port has an output latch. A latch bit of 1 drives its line, and a latch bit of 0 releases the line so that it can act as an input. A port read returns the synchronised pin levels, not the latch contents.

The lines of the first three ports (lines 0 to 23) feed edge detectors. Each of these lines has an enable bit and a polarity bit that selects the rising or the falling edge. It also has a pending flag, which latches the selected edge while the line is enabled. The three interrupt registers at offsets 8 to 10 are banked. The page register at offset 7 chooses whether they show the enable bits, the polarity bits or the pending flags. Software acknowledges a line by clearing its enable bit and then setting it again. A status byte gives one summary bit per interrupt-capable port, and a single interrupt output is the OR of every pending flag.

Top module: `pio_edge_irq`

## Requirements
- R1: After reset, every latch, enable bit, polarity bit and pending flag is 0, `irq_o` is 0, and offset 7 reads 0xC0.
- R2: Writing offset p (0 to 5) loads `drive_o[8p+7:8p]`, so line n is bit n%8 of port n/8. Reading offset p returns the pin levels two clock edges after they were sampled, whatever the latch holds.
- R3: The page register keeps write bits 7:6 and reads back as {bits,000000}. The codes are: 0x80 for the enable page, 0x40 for the polarity page, 0xC0 for the identification page, and 0x00 for no page, on which offsets 8 to 10 read 0 and ignore writes.
- R4: Offset 8+p (p = 0 to 2) is port p's enable byte on the enable page, its polarity byte on the polarity page and its pending byte on the identification page. A polarity bit of 1 selects the rising edge and 0 selects the falling edge.
- R5: A pin change on an enabled line with the matching edge sets that line's pending flag on the third clock edge after the change. The opposite edge sets nothing.
- R6: A pending flag never sets while its enable bit is 0, and an edge that occurred while the line was disabled is not remembered.
- R7: Writing 0 to an enable bit clears that line's pending flag at that write's clock edge. Setting the bit to 1 again does not bring the flag back.
- R8: Offset 6 bits 2:0 are the OR of the pending flags of ports 0, 1 and 2. Bits 7:3 read 0, and writes to offset 6 have no effect. `irq_o` is 1 exactly when any pending flag is set.
- R9: Lines 24 to 47 never set a pending flag or raise `irq_o`.
- R10: On the identification page, writes to offsets 8 to 10 leave the enable and polarity bits unchanged. Offsets 11 to 15 read 0.
- R11: An edge captured in the same cycle as a write that clears the line's enable bit leaves the flag at 0. An edge captured in the same cycle as a write that keeps the enable bit at 1 sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 4 | Register offset in the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 48 | Pin levels |
| drive_o | output | 48 | Per-line drive enable, taken from the port latches |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The edge detector and the acknowledge write can act on the same pending flag in the same clock cycle. The bench provokes this by changing a pin and then issuing the enable write so that the write lands exactly on the third clock edge after the change, the edge at which the detector captures. The flag is then read on the identification page. It must be 0 when the write cleared the enable bit, and 1 when the write left the enable bit set.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
  localparam logic [ADDR_W-1:0] A_PAGE = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQ0 = 4'd8;

  typedef enum logic [1:0] {
    PG_NONE = 2'b00,
    PG_POL  = 2'b01,
    PG_EN   = 2'b10,
    PG_ID   = 2'b11
  } page_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         pol_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q, pol_q, pend_q, prev_q;
  logic [W-1:0] hit, en_n;

  // rising where pol=1, falling where pol=0
  assign hit  = (pol_q & lvl_i & ~prev_q) | (~pol_q & ~lvl_i & prev_q);
  assign en_n = en_we_i ? wdata_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
      en_q   <= en_n;
      if (pol_we_i) pol_q <= wdata_i;
      // a cleared enable wins over a same-cycle edge
      pend_q <= en_n & (pend_q | (hit & en_q));
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*DATA_W-1:0]   pin_i,
  output logic [NUM_PORTS*DATA_W-1:0]   drive_o,
  output logic                          irq_o
);
  localparam int NUM_LINES = NUM_PORTS * DATA_W;
  localparam int IRQ_LINES = IRQ_PORTS * DATA_W;

  logic [DATA_W-1:0]    port_q [NUM_PORTS];
  logic [NUM_LINES-1:0] lvl;
  page_e                page_q;
  logic [IRQ_LINES-1:0] en_flat, pol_flat, pend_flat;
  logic [IRQ_PORTS-1:0] summary;

  // output latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) port_q[p] <= '0;
    end else if (we_i) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (addr_i == ADDR_W'(p)) port_q[p] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        page_q <= PG_ID;
    else if (we_i && addr_i == A_PAGE)  page_q <= page_e'(wdata_i[7:6]);
  end

  pio_sync #(.W(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_drv
    assign drive_o[p*DATA_W +: DATA_W] = port_q[p];
  end

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
    logic sel;
    assign sel = we_i && (addr_i == A_IRQ0 + ADDR_W'(p));
    pio_irq_port #(.W(DATA_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (sel && page_q == PG_EN),
      .pol_we_i (sel && page_q == PG_POL),
      .wdata_i  (wdata_i),
      .lvl_i    (lvl[p*DATA_W +: DATA_W]),
      .en_o     (en_flat[p*DATA_W +: DATA_W]),
      .pol_o    (pol_flat[p*DATA_W +: DATA_W]),
      .pend_o   (pend_flat[p*DATA_W +: DATA_W])
    );
    assign summary[p] = |pend_flat[p*DATA_W +: DATA_W];
  end

  assign irq_o = |summary;

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == ADDR_W'(p)) rdata_o = lvl[p*DATA_W +: DATA_W];
    if (addr_i == A_STAT) rdata_o = DATA_W'(summary);
    if (addr_i == A_PAGE) rdata_o = {page_q, 6'b0};
    for (int p = 0; p < IRQ_PORTS; p++) begin
      if (addr_i == A_IRQ0 + ADDR_W'(p)) begin
        unique case (page_q)
          PG_EN:   rdata_o = en_flat[p*DATA_W +: DATA_W];
          PG_POL:  rdata_o = pol_flat[p*DATA_W +: DATA_W];
          PG_ID:   rdata_o = pend_flat[p*DATA_W +: DATA_W];
          default: rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pio_edge_irq_chk.sv
module pio_edge_irq_chk #(
  parameter int IRQ_LINES = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [3:0]           addr_i,
  input logic [7:0]           wdata_i,
  input logic [7:0]           drive_lo,
  input logic [1:0]           page,
  input logic [IRQ_LINES-1:0] en,
  input logic [IRQ_LINES-1:0] pol,
  input logic [IRQ_LINES-1:0] pend
);
  assert_port_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd0) |=> (drive_lo == $past(wdata_i)));

  assert_page_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd7) |=> (page == $past(wdata_i[7:6])));

  assert_no_pend_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~en) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd8 && page == 2'b10 && !wdata_i[0]) |=> !pend[0]);

  assert_id_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= 4'd8 && addr_i <= 4'd10 && page == 2'b11)
      |=> ($stable(en) && $stable(pol)));
endmodule

bind pio_edge_irq pio_edge_irq_chk #(.IRQ_LINES(IRQ_PORTS * pio_pkg::DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .drive_lo (drive_o[7:0]),
  .page     (page_q),
  .en       (en_flat),
  .pol      (pol_flat),
  .pend     (pend_flat)
);

// File: tb/pio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module pio_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pins = '0;
  logic [47:0] drive;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pio_edge_irq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .drive_o(drive), .irq_o(irq)
  );

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 drive", drive, 48'h0);
    chk("R1 irq", {47'h0, irq}, 48'h0);
    rd(4'd7, d); chk("R1 page", {40'h0, d}, 48'hC0);
    for (int a = 8; a < 11; a++) begin
      rd(4'(a), d); chk("R1 pend", {40'h0, d}, 48'h0);
    end
  endtask

  task automatic t_port_io();
    logic [7:0] d;
    wr(4'd0, 8'h5A);
    wr(4'd5, 8'h81);
    chk("R2 latch", drive, 48'h810000_00005A);
    pins[15:8] = 8'hE1;
    wait_n(2);
    rd(4'd1, d); chk("R2 readback", {40'h0, d}, 48'hE1);
    rd(4'd0, d); chk("R2 pins not latch", {40'h0, d}, 48'h00);
    wr(4'd0, 8'h00);
    wr(4'd5, 8'h00);
    chk("R2 release", drive, 48'h0);
    pins[15:8] = 8'h00;
    wait_n(3);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(4'd7, 8'h80); rd(4'd7, d); chk("R3 enable page", {40'h0, d}, 48'h80);
    wr(4'd7, 8'h40); rd(4'd7, d); chk("R3 polarity page", {40'h0, d}, 48'h40);
    wr(4'd7, 8'h3F); rd(4'd7, d); chk("R3 low bits dropped", {40'h0, d}, 48'h00);
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'h40); rd(4'd8, d); chk("R3 no-page write ignored", {40'h0, d}, 48'h00);
    wr(4'd7, 8'hC0); rd(4'd7, d); chk("R3 id page", {40'h0, d}, 48'hC0);
  endtask

  task automatic t_rise_ack();
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd8, 8'h08);
    wr(4'd7, 8'h80); wr(4'd8, 8'h08);
    rd(4'd8, d); chk("R4 enable view", {40'h0, d}, 48'h08);
    wr(4'd7, 8'h40); rd(4'd8, d); chk("R4 polarity view", {40'h0, d}, 48'h08);
    wr(4'd7, 8'hC0);
    pins[3] = 1'b1;
    wait_n(2);
    rd(4'd8, d); chk("R5 not before third edge", {40'h0, d}, 48'h00);
    wait_n(1);
    rd(4'd8, d); chk("R5 rising pending", {40'h0, d}, 48'h08);
    rd(4'd6, d); chk("R8 summary port0", {40'h0, d}, 48'h01);
    chk("R8 irq set", {47'h0, irq}, 48'h1);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd8, 8'h08);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R7 ack clears", {40'h0, d}, 48'h00);
    chk("R7 irq clear", {47'h0, irq}, 48'h0);
    pins[3] = 1'b0;
    wait_n(4);
    rd(4'd8, d); chk("R5 opposite edge ignored", {40'h0, d}, 48'h00);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd7, 8'hC0);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    pins[17] = 1'b1;
    wait_n(3);
    wr(4'd7, 8'h40); wr(4'd10, 8'h00);
    wr(4'd7, 8'h80); wr(4'd10, 8'h02);
    wr(4'd7, 8'hC0);
    pins[17] = 1'b0;
    wait_n(3);
    rd(4'd10, d); chk("R5 falling pending", {40'h0, d}, 48'h02);
    rd(4'd6, d); chk("R8 summary port2", {40'h0, d}, 48'h04);
    wr(4'd7, 8'h80); wr(4'd10, 8'h00); wr(4'd7, 8'hC0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    pins[18] = 1'b1; wait_n(3);
    pins[18] = 1'b0; wait_n(3);
    rd(4'd10, d); chk("R6 disabled no pending", {40'h0, d}, 48'h00);
    wr(4'd7, 8'h80); wr(4'd10, 8'h04); wr(4'd7, 8'hC0);
    wait_n(3);
    rd(4'd10, d); chk("R6 past edge not remembered", {40'h0, d}, 48'h00);
    chk("R6 irq low", {47'h0, irq}, 48'h0);
    wr(4'd7, 8'h80); wr(4'd10, 8'h00); wr(4'd7, 8'hC0);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd8, 8'h20); wr(4'd10, 8'h10);
    wr(4'd7, 8'h80); wr(4'd8, 8'h20); wr(4'd10, 8'h10);
    wr(4'd7, 8'hC0);
    pins[5] = 1'b1; pins[20] = 1'b1;
    wait_n(3);
    rd(4'd6, d); chk("R8 two ports", {40'h0, d}, 48'h05);
    rd(4'd9, d); chk("R8 port1 idle", {40'h0, d}, 48'h00);
    wr(4'd6, 8'hFF);
    rd(4'd6, d); chk("R8 status write ignored", {40'h0, d}, 48'h05);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd10, 8'h00); wr(4'd7, 8'hC0);
    rd(4'd6, d); chk("R8 all acked", {40'h0, d}, 48'h00);
    chk("R8 irq dropped", {47'h0, irq}, 48'h0);
  endtask

  task automatic t_upper();
    logic [7:0] d;
    pins[47:24] = 24'hC35A96;
    wait_n(3);
    rd(4'd3, d); chk("R9 port3 read", {40'h0, d}, 48'h96);
    rd(4'd4, d); chk("R9 port4 read", {40'h0, d}, 48'h5A);
    rd(4'd5, d); chk("R9 port5 read", {40'h0, d}, 48'hC3);
    pins[47:24] = 24'h0;
    wait_n(3);
    rd(4'd6, d); chk("R9 no status", {40'h0, d}, 48'h00);
    chk("R9 no irq", {47'h0, irq}, 48'h0);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd9, 8'h3C);
    wr(4'd7, 8'hC0); wr(4'd9, 8'hFF);
    wr(4'd7, 8'h80); rd(4'd9, d); chk("R10 enable kept", {40'h0, d}, 48'h3C);
    wr(4'd7, 8'h40); rd(4'd9, d); chk("R10 polarity kept", {40'h0, d}, 48'h00);
    wr(4'd9, 8'h00); wr(4'd7, 8'h80); wr(4'd9, 8'h00); wr(4'd7, 8'hC0);
    for (int a = 11; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), d); chk("R10 unused offset", {40'h0, d}, 48'h00);
    end
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd9, 8'h01);
    wr(4'd7, 8'h80); wr(4'd9, 8'h01);
    // pin change at N0; detector captures at the 3rd edge, when the write lands
    @(negedge clk); pins[8] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 4'd9; wdata = 8'h00;
    @(negedge clk); we = 1'b0;
    wr(4'd7, 8'hC0);
    rd(4'd9, d); chk("R11 clearing write wins", {40'h0, d}, 48'h00);
    chk("R11 irq low", {47'h0, irq}, 48'h0);
    pins[8] = 1'b0;
    wait_n(3);
    wr(4'd7, 8'h80); wr(4'd9, 8'h01);
    @(negedge clk); pins[8] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 4'd9; wdata = 8'h01;
    @(negedge clk); we = 1'b0;
    wr(4'd7, 8'hC0);
    rd(4'd9, d); chk("R11 keeping write captures", {40'h0, d}, 48'h01);
    chk("R11 irq high", {47'h0, irq}, 48'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_port_io();
    t_page();
    t_rise_ack();
    t_fall();
    t_disabled();
    t_summary();
    t_upper();
    t_ignored();
    t_collision();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule